// File: doc/BRIEF.md
# Low-Power Clock Source Switch Controller

This block picks the clock that drives a small processor core. It chooses among three sources: the main oscillator, an internal RC oscillator, and a slow secondary oscillator of about 32 kHz. Software writes a 2-bit source code. An enable bit for the secondary oscillator can change that code before it takes effect. When the secondary oscillator becomes the target, the block turns off the main oscillator and clears the start-up flag. It keeps the core's four-phase sequencer parked in its first phase until the secondary clock has shown eight falling edges. It then raises a running flag, waits one more secondary period, and hands the new clock to the core.

The oscillators arrive as digital waveforms. They are oversampled by a fast free-running control clock. Every source passes through a two-flop synchronizer. The system clock output is a registered, gated copy of the synchronized source that is currently selected. A switch stops the old source only while it is low, and starts the new source only while it is low, so no shortened pulse reaches the core.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset the held code is 00, the running flag is 0, the start-up flag is 1, the main-oscillator shutdown is 0, the phase output is 0 (Q1), and the system clock follows the main oscillator with the same period.
- R2: The written code is adjusted before use. When the secondary enable is 0, a code with bit 0 set has bit 0 cleared, so 01 becomes 00 and 11 becomes 10. With the enable at 1, the code is used as written.
- R3: A write starts a switch only when the adjusted code differs from the held code. Otherwise the held code, the flags and the clock are unchanged.
- R4: A switch to a code with bit 0 set (the secondary oscillator) sets the shutdown output and clears the start-up flag. The held code shows the new value in the cycle after the write.
- R5: During a switch to the secondary oscillator, the phase output stays 0 (Q1), the system clock stays low, and the running flag stays 0 until eight falling edges of the synchronized secondary clock have been seen.
- R6: The running flag goes to 1 once the eighth falling edge has been counted, and stays 1 only while the held code has bit 0 set.
- R7: The system clock stays low for one further secondary period after the eighth falling edge. It then follows the secondary clock with that clock's period. The phase output advances 0→1→2→3→0 by one step on each system-clock rising edge, and the first edge gives 1.
- R8: No high or low level of the system clock lasts less than two control-clock cycles.
- R9: Leaving the secondary oscillator clears the running flag and the shutdown output right away. When the target is code 00, the start-up flag returns to 1 once the main oscillator drives the system clock.
- R10: Code 10 selects the internal RC oscillator, and the system clock then has its period.
- R11: A write made while a switch is still in progress is ignored, and the held code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast control clock that oversamples all sources |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_osc_i | input | 1 | Main oscillator waveform |
| rc_osc_i | input | 1 | Internal RC oscillator waveform |
| sec_osc_i | input | 1 | Secondary low-power oscillator waveform |
| sec_en_i | input | 1 | Secondary oscillator enable |
| sel_wr_i | input | 1 | One-cycle write strobe for the source code |
| sel_data_i | input | 2 | Source code to write |
| sel_o | output | 2 | Held source code |
| sys_clk_o | output | 1 | Gated system clock |
| qphase_o | output | 2 | Current sequencer phase, 0 means Q1 |
| pri_shdn_o | output | 1 | Main oscillator shutdown enable |
| osts_o | output | 1 | Start-up status flag |
| sec_run_o | output | 1 | Secondary oscillator drives the core |

## Verification
The no-runt and phase-step properties assume that every source stays high and low for at least two control-clock cycles. The bench drives the main, RC and secondary waveforms with half periods of 2, 5 and 20 control cycles, and offsets their edges from the control clock. The edge-count properties assume the secondary clock is steady throughout a switch, which the bench keeps. It issues a switch right after a secondary rising edge, so the first falling edge arrives after the old source has been stopped. Writes are one-cycle strobes driven away from the active clock edge.

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int FALL_COUNT = 8,
  parameter int DLY_FALLS  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pri_osc_i,
  input  logic       rc_osc_i,
  input  logic       sec_osc_i,
  input  logic       sec_en_i,
  input  logic       sel_wr_i,
  input  logic [1:0] sel_data_i,
  output logic [1:0] sel_o,
  output logic       sys_clk_o,
  output logic [1:0] qphase_o,
  output logic       pri_shdn_o,
  output logic       osts_o,
  output logic       sec_run_o
);

  localparam int CW = $clog2(FALL_COUNT + DLY_FALLS + 1);
  localparam logic [1:0] SRC_PRI = 2'd0;
  localparam logic [1:0] SRC_RC  = 2'd1;
  localparam logic [1:0] SRC_SEC = 2'd2;

  typedef enum logic [2:0] {S_RUN, S_STOP, S_HOLD, S_DLY, S_START} st_e;

  st_e           st;
  logic [2:0]    sy1, sy2;
  logic          sec_d;
  logic [1:0]    sel_q, cur, nxt, ph;
  logic          gate, clk_q, osts_q, shdn_q, srun_q;
  logic [CW-1:0] cnt;

  function automatic logic [1:0] src_of(input logic [1:0] c);
    return c[0] ? SRC_SEC : (c[1] ? SRC_RC : SRC_PRI);
  endfunction

  wire [1:0] wr_fin   = sec_en_i ? sel_data_i : {sel_data_i[1], 1'b0};
  wire       sw_req   = sel_wr_i && (st == S_RUN) && (wr_fin != sel_q);
  wire       sec_fall = sec_d & ~sy2[2];
  wire       cur_clk  = sy2[cur];
  wire       nxt_clk  = sy2[nxt];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy1   <= '0;
      sy2   <= '0;
      sec_d <= 1'b0;
    end else begin
      sy1   <= {sec_osc_i, rc_osc_i, pri_osc_i};
      sy2   <= sy1;
      sec_d <= sy2[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_RUN;
      sel_q  <= 2'b00;
      cur    <= SRC_PRI;
      nxt    <= SRC_PRI;
      gate   <= 1'b1;
      clk_q  <= 1'b0;
      ph     <= 2'd0;
      cnt    <= '0;
      osts_q <= 1'b1;
      shdn_q <= 1'b0;
      srun_q <= 1'b0;
    end else begin
      clk_q <= gate & cur_clk;
      if (gate && cur_clk && !clk_q) ph <= ph + 2'd1;
      case (st)
        S_RUN: if (sw_req) begin
          sel_q <= wr_fin;
          nxt   <= src_of(wr_fin);
          st    <= S_STOP;
          if (wr_fin[0]) begin
            osts_q <= 1'b0;
            shdn_q <= 1'b1;
          end else if (sel_q[0]) begin
            srun_q <= 1'b0;
            shdn_q <= 1'b0;
          end
        end
        S_STOP: if (!cur_clk) begin
          gate <= 1'b0;
          ph   <= 2'd0;
          cnt  <= '0;
          st   <= (nxt == SRC_SEC) ? S_HOLD : S_START;
        end
        S_HOLD: if (sec_fall) begin
          if (cnt == CW'(FALL_COUNT - 1)) begin
            cnt    <= '0;
            srun_q <= 1'b1;
            st     <= S_DLY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DLY: if (sec_fall) begin
          if (cnt == CW'(DLY_FALLS - 1)) begin
            cnt <= '0;
            st  <= S_START;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_START: if (!nxt_clk) begin
          gate <= 1'b1;
          cur  <= nxt;
          st   <= S_RUN;
          if (nxt == SRC_PRI) osts_q <= 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign sel_o      = sel_q;
  assign sys_clk_o  = clk_q;
  assign qphase_o   = ph;
  assign pri_shdn_o = shdn_q;
  assign osts_o     = osts_q;
  assign sec_run_o  = srun_q;

endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_wr_i,
  input logic       sec_en_i,
  input logic [1:0] sel_data_i,
  input logic [1:0] sel_o,
  input logic       sys_clk_o,
  input logic [1:0] qphase_o,
  input logic       pri_shdn_o,
  input logic       osts_o,
  input logic       sec_run_o,
  input logic       st_run,
  input logic       st_hold
);

  wire [1:0] adj = sec_en_i ? sel_data_i : {sel_data_i[1], 1'b0};

  p_rewrite_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !sec_en_i && st_run) |=> !sel_o[0]);

  p_noevent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && st_run && adj == sel_o) |=> (st_run && $stable(sel_o)));

  p_shdn_osts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_shdn_o |-> !osts_o);

  p_hold_q1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_hold |-> (qphase_o == 2'd0 && !sys_clk_o));

  p_run_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_run_o |-> sel_o[0]);

  p_phase_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qphase_o != $past(qphase_o)) |->
      (qphase_o == $past(qphase_o) + 2'd1 || qphase_o == 2'd0));

  p_no_runt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_clk_o != $past(sys_clk_o)) |=> $stable(sys_clk_o));

  p_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !st_run) |=> $stable(sel_o));

endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_wr_i   (sel_wr_i),
  .sec_en_i   (sec_en_i),
  .sel_data_i (sel_data_i),
  .sel_o      (sel_o),
  .sys_clk_o  (sys_clk_o),
  .qphase_o   (qphase_o),
  .pri_shdn_o (pri_shdn_o),
  .osts_o     (osts_o),
  .sec_run_o  (sec_run_o),
  .st_run     (st == S_RUN),
  .st_hold    (st == S_HOLD || st == S_DLY)
);

// File: tb/tb_clksw_ctrl.sv
module tb_clksw_ctrl;
  localparam int CLK_T = 10;

  logic clk = 0, rst_n = 0;
  logic pri = 0, rc = 0, sec = 0;
  logic sec_en = 0, sel_wr = 0;
  logic [1:0] sel_data = 0;
  logic [1:0] sel, qph;
  logic sys_clk, shdn, osts, srun;
  int total = 0, bad = 0, runts = 0, run_len = 100;
  logic last_clk = 0;
  bit done = 0;

  clksw_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pri_osc_i(pri), .rc_osc_i(rc), .sec_osc_i(sec),
    .sec_en_i(sec_en), .sel_wr_i(sel_wr), .sel_data_i(sel_data),
    .sel_o(sel), .sys_clk_o(sys_clk), .qphase_o(qph),
    .pri_shdn_o(shdn), .osts_o(osts), .sec_run_o(srun)
  );

  always #(CLK_T/2) clk = ~clk;
  initial begin #3;  forever #20  pri = ~pri; end
  initial begin #7;  forever #50  rc  = ~rc;  end
  initial begin #11; forever #200 sec = ~sec; end

  always @(negedge clk) if (rst_n) begin
    if (sys_clk != last_clk) begin
      if (run_len < 2) runts++;
      run_len = 1;
    end else run_len++;
    last_clk = sys_clk;
  end

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] code);
    @(negedge clk);
    sel_wr = 1; sel_data = code;
    @(negedge clk);
    sel_wr = 0;
  endtask

  task automatic wait_rise();
    logic p;
    p = sys_clk;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sys_clk && !p) return;
      p = sys_clk;
    end
  endtask

  task automatic period(output int p);
    wait_rise();
    p = 0;
    for (int i = 0; i < 400; i++) begin
      logic q;
      q = sys_clk;
      @(negedge clk);
      p++;
      if (sys_clk && !q) break;
    end
  endtask

  task automatic t_reset();
    int p;
    chk("R1 sel", sel, 0);
    chk("R1 run", srun, 0);
    chk("R1 osts", osts, 1);
    chk("R1 shdn", shdn, 0);
    chk("R1 phase", qph, 0);
    period(p);
    chk("R1 primary period", p, 4);
  endtask

  task automatic t_rewrite();
    int p;
    sec_en = 0;
    wr(2'b01);
    chk("R2 01->00 sel", sel, 0);
    chk("R3 no event osts", osts, 1);
    chk("R3 no event shdn", shdn, 0);
    wr(2'b11);
    chk("R2 11->10 sel", sel, 2);
    chk("R2 shdn", shdn, 0);
    tick(40);
    period(p);
    chk("R10 rc period", p, 10);
  endtask

  task automatic t_same();
    int p;
    wr(2'b10);
    chk("R3 same code sel", sel, 2);
    period(p);
    chk("R3 same code period", p, 10);
    chk("R3 same code osts", osts, 1);
  endtask

  task automatic t_tosec();
    int p, err = 0;
    logic [1:0] ph0;
    sec_en = 1;
    @(posedge sec);
    wr(2'b01);
    chk("R4 sel", sel, 1);
    chk("R4 osts", osts, 0);
    chk("R4 shdn", shdn, 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge sec);
      #1;
      if (qph != 0 || srun != 0) err++;
      if (k == 3) wr(2'b10);
    end
    chk("R5 held in Q1 until 8 falls", err, 0);
    chk("R11 write during switch ignored", sel, 1);
    tick(5);
    chk("R6 running flag set", srun, 1);
    tick(20);
    chk("R7 clock still off for one period", sys_clk, 0);
    wait_rise();
    chk("R7 first phase", qph, 1);
    ph0 = qph;
    err = 0;
    for (int i = 0; i < 4; i++) begin
      wait_rise();
      if (qph != ph0 + 2'd1) err++;
      ph0 = qph;
    end
    chk("R7 phase sequence", err, 0);
    period(p);
    chk("R7 secondary period", p, 40);
    chk("R6 run kept", srun, 1);
  endtask

  task automatic t_back();
    int p;
    wr(2'b00);
    chk("R9 run cleared", srun, 0);
    chk("R9 shdn cleared", shdn, 0);
    tick(60);
    chk("R9 osts restored", osts, 1);
    chk("R9 sel", sel, 0);
    period(p);
    chk("R9 primary period", p, 4);
    chk("R8 no runt pulses", runts, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rewrite();
    t_same();
    t_tosec();
    t_back();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule